// File: doc/BRIEF.md
# Parity-Guarded Interrupt Vector Table

This block holds a table of handler addresses, one 32-bit word per interrupt entry, and keeps one parity bit beside each word. Parity is produced whenever software writes an entry. It is checked again each time an entry leaves the table, either through the vector fetch port or through a register-bus read. When checking is armed and a fetched word fails its parity check, the block does not hand out the corrupted word. It returns a software-programmed fallback handler address in its place.

Every detected error gives a one-cycle pulse. The first error also sets a sticky flag and records the failing entry's byte offset, and software clears the flag by writing 1 to it. The fallback handler can turn the recorded offset back into an entry index and rewrite that entry. Writing an entry always recomputes its parity, so a rewrite repairs it. A test input inverts the parity bit stored by the next table write, which gives a controlled way to plant a corrupted entry.

Each fetch request is an index offered with valid/ready. A request is taken on a clock edge where `fetch_valid` and `fetch_ready` are both high. The vector is registered and shows on `vec_data` with `vec_valid` one clock later. The vector stays valid and unchanged until a clock edge where `vec_ready` is high. A new request is taken only when the output register is empty or is being drained in that same cycle. The register bus is plain: it has write and read strobes, and read data comes back one clock after the read strobe.

Top module: `vtab_guard`

## Requirements
- R1: A register-bus write to byte offset 4*i, for i from 0 to 127 (offsets 0x000 to 0x1FC), stores the word in entry i. A read of that offset returns the word one clock after `reg_rd`, with `reg_rvalid` high in that cycle.
- R2: A fetch is taken on an edge with `fetch_valid` and `fetch_ready` both high, and the entry's vector appears on `vec_data` with `vec_valid` high after that edge. While `vec_valid` is high and `vec_ready` is low, `vec_data` holds its value, `fetch_ready` is low and no new request is taken.
- R3: Parity checking is armed only while bits 3:0 of the control register (offset 0x200) equal 0xA. With any other value, a corrupted entry is returned unchanged, no pulse is given and the flag stays clear.
- R4: With checking armed, a fetch of an entry whose parity fails returns the fallback register (offset 0x204) instead of the stored word.
- R5: `par_err_pulse` is high for exactly one cycle for each detected error, in the cycle that follows the edge where the failing read is taken.
- R6: The error flag (bit 0 at offset 0x20C) is set by any detected error and stays set. Writing 1 to it clears it, writing 0 has no effect, and a new error in the same cycle as a clear leaves the flag set.
- R7: The error-address register (offset 0x208, read-only) gets the failing entry's byte offset 4*i, so bits 8:2 hold the index and all other bits are zero. It is loaded only while the flag is clear, so the first error is kept.
- R8: A bus read of a corrupted entry with checking armed returns the stored word unchanged, but it sets the flag, loads the error address and pulses.
- R9: A new write to an entry stores even parity for the new word, so a later fetch returns the new word with no error.
- R10: After reset the control field is 0x5 (checking off), the fallback, error address and flag are zero, `vec_valid` is low, and every entry reads as zero.
- R11: When a fetch and a bus read both detect an error in the same cycle, the error address records the fetched entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register-bus write strobe |
| reg_rd | input | 1 | Register-bus read strobe |
| reg_addr | input | 10 | Byte address on the register bus |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one clock after reg_rd |
| par_flip | input | 1 | Test input: inverts the stored parity bit of a table write in the same cycle |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request can be taken |
| fetch_idx | input | 7 | Entry index to fetch |
| vec_valid | output | 1 | Vector output valid |
| vec_ready | input | 1 | Consumer takes the vector |
| vec_data | output | 32 | Vector, or the fallback after a parity error |
| par_err_pulse | output | 1 | One-cycle pulse per detected parity error |

## Verification
The hardest cases to reach from the ports involve timing. Two errors can be detected in the same cycle, one by a fetch and one by a bus read, and an error can arrive in the same cycle that software clears the flag. Both need the fetch port and the register bus driven on one edge. The bench first plants corrupted entries with `par_flip` and arms checking. It then drives the fetch request together with a bus read or a flag-clear write at a single negative edge, and reads the flag and error address back over the bus afterwards.

// File: rtl/vtab_pkg.sv
`timescale 1ns/1ps
package vtab_pkg;
  localparam int unsigned VT_ENTRIES = 128;
  localparam int unsigned VT_DW      = 32;
  localparam int unsigned KEY_W      = 4;
  localparam logic [KEY_W-1:0] KEY_ARM = 4'hA;
  localparam logic [KEY_W-1:0] KEY_RST = 4'h5;

  // register select from address bits 3:2 inside the control block
  typedef enum logic [1:0] {
    CSR_CTRL     = 2'd0,
    CSR_FALLBACK = 2'd1,
    CSR_ERRADDR  = 2'd2,
    CSR_FLAG     = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/vtab_store.sv
`timescale 1ns/1ps
module vtab_store
  import vtab_pkg::*;
#(
  parameter int unsigned ENTRIES = VT_ENTRIES,
  parameter int unsigned DW      = VT_DW,
  parameter int unsigned NPORT   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [DW-1:0]              wr_data,
  input  logic                       wr_flip,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx  [NPORT],
  output logic [DW-1:0]              rd_data [NPORT],
  output logic                       rd_bad  [NPORT]
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  // bit DW holds the even-parity bit of the word
  logic [DW:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {(^wr_data) ^ wr_flip, wr_data};
    end
  end

  // independent combinational read ports, each with its own checker tree
  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [DW:0] word;
    assign word       = mem[rd_idx[p]];
    assign rd_data[p] = word[DW-1:0];
    assign rd_bad[p]  = ^word;
  end

  logic [IDX_W-1:0] last_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_idx <= '0;
    else        last_idx <= wr_idx;
  end

  // R9
  parity_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_flip |=> (^mem[last_idx]) == 1'b0);
endmodule

// File: rtl/vtab_fetch.sv
`timescale 1ns/1ps
module vtab_fetch
  import vtab_pkg::*;
#(
  parameter int unsigned ENTRIES = VT_ENTRIES,
  parameter int unsigned DW      = VT_DW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_valid,
  output logic                       fetch_ready,
  input  logic [$clog2(ENTRIES)-1:0] fetch_idx,
  output logic                       vec_valid,
  input  logic                       vec_ready,
  output logic [DW-1:0]              vec_data,
  input  logic [DW-1:0]              tbl_data,
  input  logic                       tbl_bad,
  input  logic                       chk_en,
  input  logic [DW-1:0]              fallback,
  output logic                       fetch_err
);
  logic          take;
  logic          out_v_q;
  logic [DW-1:0] out_d_q;
  logic [DW-1:0] pick;

  assign fetch_ready = !out_v_q || vec_ready;
  assign take        = fetch_valid && fetch_ready;
  assign fetch_err   = take && chk_en && tbl_bad;
  assign pick        = (chk_en && tbl_bad) ? fallback : tbl_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else begin
      if (take) begin
        out_v_q <= 1'b1;
        out_d_q <= pick;
      end else if (vec_ready) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign vec_valid = out_v_q;
  assign vec_data  = out_d_q;

  // R2
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_data));
  // R2
  fetch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> vec_valid);
  // R4
  fallback_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |=> vec_data == $past(fallback));
endmodule

// File: rtl/vtab_regs.sv
`timescale 1ns/1ps
module vtab_regs
  import vtab_pkg::*;
#(
  parameter int unsigned ENTRIES = VT_ENTRIES,
  parameter int unsigned DW      = VT_DW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [$clog2(ENTRIES)+2:0]   reg_addr,
  input  logic [DW-1:0]                reg_wdata,
  output logic [DW-1:0]                reg_rdata,
  output logic                         reg_rvalid,
  output logic                         tbl_we,
  output logic [$clog2(ENTRIES)-1:0]   tbl_idx,
  input  logic [DW-1:0]                tbl_rdata,
  input  logic                         tbl_rbad,
  input  logic                         fetch_err,
  input  logic [$clog2(ENTRIES)-1:0]   fetch_err_idx,
  output logic                         chk_en,
  output logic [DW-1:0]                fallback,
  output logic                         err_pulse
);
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned ADDR_W = IDX_W + 3;

  logic [KEY_W-1:0] key_q;
  logic [DW-1:0]    fb_q;
  logic [DW-1:0]    eaddr_q;
  logic             flag_q;
  logic             pulse_q;

  logic             in_tbl;
  logic             csr_hit;
  csr_sel_e         sel;
  logic             rd_err;
  logic             any_err;
  logic             flag_clr;
  logic [IDX_W-1:0] err_idx;

  assign in_tbl  = !reg_addr[ADDR_W-1];
  assign csr_hit = reg_addr[ADDR_W-1] && (reg_addr[ADDR_W-2:4] == '0) &&
                   (reg_addr[1:0] == 2'b00);
  assign sel     = csr_sel_e'(reg_addr[3:2]);
  assign tbl_idx = reg_addr[IDX_W+1:2];
  assign tbl_we  = reg_wr && in_tbl;

  assign chk_en   = (key_q == KEY_ARM);
  assign rd_err   = reg_rd && in_tbl && chk_en && tbl_rbad;
  assign any_err  = fetch_err || rd_err;
  assign err_idx  = fetch_err ? fetch_err_idx : tbl_idx;
  assign flag_clr = reg_wr && csr_hit && (sel == CSR_FLAG) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= KEY_RST;
      fb_q    <= '0;
    end else if (reg_wr && csr_hit) begin
      if (sel == CSR_CTRL)     key_q <= reg_wdata[KEY_W-1:0];
      if (sel == CSR_FALLBACK) fb_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      eaddr_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= any_err;
      if (any_err) begin
        flag_q <= 1'b1;
        if (!flag_q) eaddr_q <= DW'({err_idx, 2'b00});
      end else if (flag_clr) begin
        flag_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        if (in_tbl) reg_rdata <= tbl_rdata;
        else if (!csr_hit) reg_rdata <= '0;
        else begin
          unique case (sel)
            CSR_CTRL:     reg_rdata <= DW'(key_q);
            CSR_FALLBACK: reg_rdata <= fb_q;
            CSR_ERRADDR:  reg_rdata <= eaddr_q;
            CSR_FLAG:     reg_rdata <= DW'(flag_q);
          endcase
        end
      end
    end
  end

  assign fallback  = fb_q;
  assign err_pulse = pulse_q;

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr |=> flag_q);
  // R7
  eaddr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> $stable(eaddr_q));
  // R7
  eaddr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eaddr_q[1:0] == 2'b00) && ((eaddr_q >> (IDX_W + 2)) == '0));
  // R5
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> flag_q);
  // R3
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !err_pulse);
endmodule

// File: rtl/vtab_guard.sv
`timescale 1ns/1ps
module vtab_guard
  import vtab_pkg::*;
#(
  parameter int unsigned ENTRIES = VT_ENTRIES,
  parameter int unsigned DW      = VT_DW,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  input  logic              par_flip,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [IDX_W-1:0]  fetch_idx,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [DW-1:0]     vec_data,
  output logic              par_err_pulse
);
  localparam int unsigned P_FETCH = 0;
  localparam int unsigned P_BUS   = 1;

  logic             tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  logic [IDX_W-1:0] rd_idx  [2];
  logic [DW-1:0]    rd_data [2];
  logic             rd_bad  [2];
  logic             chk_en;
  logic [DW-1:0]    fallback;
  logic             fetch_err;

  assign rd_idx[P_FETCH] = fetch_idx;
  assign rd_idx[P_BUS]   = tbl_idx;

  vtab_store #(.ENTRIES(ENTRIES), .DW(DW), .NPORT(2)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_data (reg_wdata),
    .wr_flip (par_flip),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .rd_bad  (rd_bad)
  );

  vtab_fetch #(.ENTRIES(ENTRIES), .DW(DW)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_idx   (fetch_idx),
    .vec_valid   (vec_valid),
    .vec_ready   (vec_ready),
    .vec_data    (vec_data),
    .tbl_data    (rd_data[P_FETCH]),
    .tbl_bad     (rd_bad[P_FETCH]),
    .chk_en      (chk_en),
    .fallback    (fallback),
    .fetch_err   (fetch_err)
  );

  vtab_regs #(.ENTRIES(ENTRIES), .DW(DW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .reg_rvalid    (reg_rvalid),
    .tbl_we        (tbl_we),
    .tbl_idx       (tbl_idx),
    .tbl_rdata     (rd_data[P_BUS]),
    .tbl_rbad      (rd_bad[P_BUS]),
    .fetch_err     (fetch_err),
    .fetch_err_idx (fetch_idx),
    .chk_en        (chk_en),
    .fallback      (fallback),
    .err_pulse     (par_err_pulse)
  );

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_pulse && !(fetch_valid && fetch_ready) && !reg_rd |=> !par_err_pulse);
endmodule

// File: tb/vtab_guard_tb.sv
`timescale 1ns/1ps
module vtab_guard_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned IW = 7;
  localparam int unsigned AW = 10;
  localparam logic [AW-1:0] A_CTRL = 10'h200;
  localparam logic [AW-1:0] A_FB   = 10'h204;
  localparam logic [AW-1:0] A_EA   = 10'h208;
  localparam logic [AW-1:0] A_FLAG = 10'h20C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, par_flip = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic reg_rvalid;
  logic fetch_valid = 1'b0, vec_ready = 1'b1;
  logic fetch_ready, vec_valid, par_err_pulse;
  logic [IW-1:0] fetch_idx = '0;
  logic [DW-1:0] vec_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  vtab_guard u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .par_flip(par_flip), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_idx(fetch_idx), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_data(vec_data), .par_err_pulse(par_err_pulse)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic flip);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; par_flip = flip;
    @(negedge clk);
    reg_wr = 1'b0; par_flip = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic do_fetch(input logic [IW-1:0] i, output logic [DW-1:0] d,
                          output logic v, output logic p);
    @(negedge clk);
    vec_ready = 1'b1; fetch_valid = 1'b1; fetch_idx = i;
    @(negedge clk);
    fetch_valid = 1'b0;
    d = vec_data; v = vec_valid; p = par_err_pulse;
  endtask

  function automatic logic [AW-1:0] ent(input int i);
    return AW'(i * 4);
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d; logic v;
    chk("R10 vec_valid after reset", DW'(vec_valid), 0);
    bus_rd(A_CTRL, d, v); chk("R10 control reset", d, 32'h5);
    bus_rd(A_FB, d, v);   chk("R10 fallback reset", d, 0);
    bus_rd(A_EA, d, v);   chk("R10 error address reset", d, 0);
    bus_rd(A_FLAG, d, v); chk("R10 flag reset", d, 0);
    bus_rd(ent(77), d, v); chk("R10 entry reset", d, 0);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] d; logic v;
    bus_wr(ent(0), 32'hA5A5_0001, 1'b0);
    bus_wr(ent(127), 32'h8000_0FFF, 1'b0);
    bus_wr(ent(5), 32'h1234_5678, 1'b0);
    bus_rd(ent(0), d, v);   chk("R1 entry 0", d, 32'hA5A5_0001); chk("R1 rvalid", DW'(v), 1);
    bus_rd(ent(127), d, v); chk("R1 entry 127", d, 32'h8000_0FFF);
    bus_rd(ent(5), d, v);   chk("R1 entry 5", d, 32'h1234_5678);
  endtask

  task automatic t_fetch_plain();
    logic [DW-1:0] d; logic v, p;
    bus_wr(A_CTRL, 32'hA, 1'b0);
    do_fetch(7'd5, d, v, p);
    chk("R2 fetch entry 5", d, 32'h1234_5678); chk("R2 fetch valid", DW'(v), 1);
    chk("R5 no pulse on clean fetch", DW'(p), 0);
    do_fetch(7'd127, d, v, p); chk("R2 fetch entry 127", d, 32'h8000_0FFF);
    do_fetch(7'd0, d, v, p);   chk("R2 fetch entry 0", d, 32'hA5A5_0001);
  endtask

  task automatic t_backpressure();
    bus_wr(ent(3), 32'h0000_3333, 1'b0);
    bus_wr(ent(4), 32'h0000_4444, 1'b0);
    @(negedge clk);
    vec_ready = 1'b0; fetch_valid = 1'b1; fetch_idx = 7'd3;
    @(negedge clk);
    chk("R2 stalled vector", vec_data, 32'h0000_3333);
    chk("R2 ready low while stalled", DW'(fetch_ready), 0);
    fetch_idx = 7'd4;
    repeat (2) @(negedge clk);
    chk("R2 vector held", vec_data, 32'h0000_3333);
    chk("R2 valid held", DW'(vec_valid), 1);
    vec_ready = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R2 next vector after drain", vec_data, 32'h0000_4444);
    chk("R2 valid after drain", DW'(vec_valid), 1);
    @(negedge clk);
    chk("R2 output empties", DW'(vec_valid), 0);
  endtask

  task automatic t_disarmed();
    logic [DW-1:0] d; logic v, p;
    bus_wr(ent(9), 32'h0000_0909, 1'b1);
    bus_wr(A_FB, 32'hDEAD_0000, 1'b0);
    bus_wr(A_CTRL, 32'h3, 1'b0);
    do_fetch(7'd9, d, v, p);
    chk("R3 disarmed returns stored", d, 32'h0000_0909); chk("R3 no pulse", DW'(p), 0);
    bus_wr(A_CTRL, 32'hB, 1'b0);
    do_fetch(7'd9, d, v, p);
    chk("R3 key 0xB disarmed", d, 32'h0000_0909);
    bus_rd(A_FLAG, d, v); chk("R3 flag clear", d, 0);
  endtask

  task automatic t_fallback();
    logic [DW-1:0] d; logic v, p;
    bus_wr(A_CTRL, 32'hA, 1'b0);
    do_fetch(7'd9, d, v, p);
    chk("R4 fallback returned", d, 32'hDEAD_0000); chk("R5 pulse on error", DW'(p), 1);
    @(negedge clk); chk("R5 pulse one cycle", DW'(par_err_pulse), 0);
    bus_rd(A_FLAG, d, v); chk("R6 flag set", d, 1);
    bus_rd(A_EA, d, v);   chk("R7 error address entry 9", d, 32'h24);
  endtask

  task automatic t_first_kept();
    logic [DW-1:0] d; logic v, p;
    bus_wr(ent(20), 32'h0000_2020, 1'b1);
    do_fetch(7'd20, d, v, p);
    chk("R4 fallback entry 20", d, 32'hDEAD_0000);
    bus_rd(A_EA, d, v); chk("R7 first address kept", d, 32'h24);
    bus_wr(A_FLAG, 32'h0, 1'b0);
    bus_rd(A_FLAG, d, v); chk("R6 write 0 no effect", d, 1);
    bus_wr(A_FLAG, 32'h1, 1'b0);
    bus_rd(A_FLAG, d, v); chk("R6 write 1 clears", d, 0);
  endtask

  task automatic t_bus_read_err();
    logic [DW-1:0] d; logic v, p;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ent(20);
    @(negedge clk);
    reg_rd = 1'b0; d = reg_rdata; p = par_err_pulse;
    chk("R8 raw data on bus read", d, 32'h0000_2020); chk("R8 pulse", DW'(p), 1);
    bus_rd(A_FLAG, d, v); chk("R8 flag set", d, 1);
    bus_rd(A_EA, d, v);   chk("R8 address entry 20", d, 32'h50);
    bus_wr(A_FLAG, 32'h1, 1'b0);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] d; logic v;
    @(negedge clk);
    vec_ready = 1'b1; fetch_valid = 1'b1; fetch_idx = 7'd9;
    reg_rd = 1'b1; reg_addr = ent(20);
    @(negedge clk);
    fetch_valid = 1'b0; reg_rd = 1'b0;
    bus_rd(A_EA, d, v); chk("R11 fetch entry wins", d, 32'h24);
    bus_wr(A_FLAG, 32'h1, 1'b0);
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] d; logic v;
    @(negedge clk);
    vec_ready = 1'b1; fetch_valid = 1'b1; fetch_idx = 7'd20;
    reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 32'h1;
    @(negedge clk);
    fetch_valid = 1'b0; reg_wr = 1'b0;
    bus_rd(A_FLAG, d, v); chk("R6 error beats clear", d, 1);
    bus_rd(A_EA, d, v);   chk("R7 address captured on clear cycle", d, 32'h50);
    bus_wr(A_FLAG, 32'h1, 1'b0);
  endtask

  task automatic t_repair();
    logic [DW-1:0] d; logic v, p;
    bus_wr(ent(9), 32'hCAFE_0009, 1'b0);
    do_fetch(7'd9, d, v, p);
    chk("R9 repaired entry fetched", d, 32'hCAFE_0009); chk("R9 no pulse", DW'(p), 0);
    bus_rd(A_FLAG, d, v); chk("R9 flag stays clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_fetch_plain();
    t_backpressure();
    t_disarmed();
    t_fallback();
    t_first_kept();
    t_bus_read_err();
    t_same_cycle();
    t_set_wins();
    t_repair();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule